// File: doc/BRIEF.md
# Earliest-Deadline Hardware Task Scheduler

This block keeps a set of real-time tasks in hardware and always exposes the ready task whose absolute deadline comes first. Software drives a single command port to start one-shot tasks, to start tasks that repeat with a fixed period, to kill tasks, and to put a task to sleep for a number of time units. Two register-based sorted queues hold the live state. One queue holds the ready tasks, ordered by absolute deadline. The other holds future events, ordered by wake time. An event is either a pending release of a repeating task or the end of a sleep.

A time counter advances once per clock. When the earliest event comes due, the block handles it without software. A sleeping task goes back into the ready queue with its old deadline. A repeating task gets its next deadline and its next release time. Each queue update is one parallel compare-and-shift across all entries, so a command costs the same two cycles for any task count.

Top module: `edf_sched`

## Requirements
- R1: During reset and in the first cycle after it, `cur_valid` and `cmd_err` are 0 and `cmd_ready` is 1. `now_time` is 0 under reset and then rises by exactly one every clock.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 for the next cycle only. The command takes effect on the following edge, two edges in total. Opcode values for `cmd_op` are: 0 idle, 1 one-shot create, 2 repeating create, 3 kill, 4 sleep. Values 5 to 7 act as idle.
- R3: Whenever `cur_valid` is 1, `cur_id` names the ready task with the earliest absolute deadline. Among equal deadlines, the task that entered the ready queue first wins.
- R4: A one-shot create with relative deadline D, executed in a cycle where `now_time` is T, makes the task ready with absolute deadline T+D. T is one more than `now_time` in the accept cycle.
- R5: A repeating create with deadline D and period P makes the task ready with deadline T+D and schedules its release at T+P. At each release time R, the task re-enters the ready queue with deadline R+D, behind any equal deadlines, and its next release is set to R+P.
- R6: A kill removes the task from both queues and frees its ID.
- R7: A sleep of length L removes the task from the ready queue and sets its wake time to T+L. On waking, the task returns with its previous deadline. A sleeping repeating task keeps its pending release, and that release is re-armed after the wake.
- R8: Four cases are refused: a create on an ID in use, a kill on a free ID, a sleep on a free ID, and a sleep on an ID that is already asleep. A refused command raises `cmd_err` for the one cycle after it executes and changes no state.
- R9: At most one due event is handled per clock. An event is handled only in a cycle where no command executes. It is due when `now_time - wake` has its top bit clear.
- R10: `cur_changed` is 1 exactly in the cycles where (`cur_valid`, `cur_id` when valid) differs from its value in the cycle before.
- R11: Deadline and wake-time comparisons use modular subtraction. Ordering stays correct across counter wrap while all live times lie within half the counter range of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_id | input | $clog2(NTASK) | Target task ID |
| cmd_rdl | input | TW | Relative deadline for creates |
| cmd_period | input | TW | Period for repeating create |
| cmd_delay | input | TW | Sleep length |
| cmd_err | output | 1 | One-cycle flag for a refused command |
| cur_valid | output | 1 | At least one task is ready |
| cur_id | output | $clog2(NTASK) | Selected task |
| cur_changed | output | 1 | Selection differs from previous cycle |
| now_time | output | TW | Free-running time counter |

## Verification
The ordering assertions inside both queues rely on R11's window. Every live deadline and wake time must sit within half the counter range of every other. The stimulus holds to this with bounded deadlines, periods and sleep lengths, and it kills any one-shot task whose deadline has fallen well behind the counter. The bench uses a narrow time width, so the counter wraps many times during the random phase. That exercises the modular comparisons under the same bounds.

// File: rtl/edf_pkg.sv
package edf_pkg;
   typedef enum logic [2:0] {
      OP_IDLE        = 3'd0,
      OP_NEW_ONESHOT = 3'd1,
      OP_NEW_CYCLIC  = 3'd2,
      OP_KILL        = 3'd3,
      OP_SLEEP       = 3'd4
   } edf_op_e;
endpackage

// File: rtl/edf_time_base.sv
module edf_time_base #(
   parameter int unsigned TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wake_v,
   input  logic [TW-1:0] wake_key,
   output logic [TW-1:0] now,
   output logic          due
);
   logic [TW-1:0] lag;

   generate
      if (TW < 4) begin : g_bad_tw
         $error("edf_time_base: TW must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end

   // modular distance: top bit clear means the wake time is not in the future
   assign lag = now - wake_key;
   assign due = wake_v && !lag[TW-1];

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> now == $past(now) + 1'b1); // R1
endmodule

// File: rtl/edf_pq.sv
module edf_pq #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned KW    = 32,
   parameter int unsigned IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rm_en,
   input  logic [IW-1:0] rm_id,
   input  logic          ins_en,
   input  logic [KW-1:0] ins_key,
   input  logic [IW-1:0] ins_id,
   output logic          head_v,
   output logic [KW-1:0] head_key,
   output logic [IW-1:0] head_id
);
   logic          q_v  [DEPTH];
   logic [KW-1:0] q_k  [DEPTH];
   logic [IW-1:0] q_id [DEPTH];
   logic          shl  [DEPTH];
   logic          c_v  [DEPTH];
   logic [KW-1:0] c_k  [DEPTH];
   logic [IW-1:0] c_id [DEPTH];
   logic          n_v  [DEPTH];
   logic [KW-1:0] n_k  [DEPTH];
   logic [IW-1:0] n_id [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("edf_pq: DEPTH must be at least 2");
      end
      if (KW < 4) begin : g_bad_kw
         $error("edf_pq: KW must be at least 4");
      end
      if ((1 << IW) < DEPTH) begin : g_bad_iw
         $error("edf_pq: IW too narrow for DEPTH");
      end
   endgenerate

   function automatic logic earlier(input logic [KW-1:0] a, input logic [KW-1:0] b);
      logic [KW-1:0] d;
      d = a - b;
      return d[KW-1];
   endfunction

   // removal: every slot at or above the matching entry takes its upper neighbour
   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         seen   = seen | (rm_en && q_v[i] && (q_id[i] == rm_id));
         shl[i] = seen;
      end
   end

   always_comb begin
      logic          up_v;
      logic [KW-1:0] up_k;
      logic [IW-1:0] up_i;
      up_v = 1'b0;
      up_k = '0;
      up_i = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         c_v[i]  = shl[i] ? up_v : q_v[i];
         c_k[i]  = shl[i] ? up_k : q_k[i];
         c_id[i] = shl[i] ? up_i : q_id[i];
         up_v = q_v[i];
         up_k = q_k[i];
         up_i = q_id[i];
      end
   end

   // insertion: new entry lands behind every entry whose key is not later
   always_comb begin
      logic          prev_aft;
      logic          aft;
      logic          lo_v;
      logic [KW-1:0] lo_k;
      logic [IW-1:0] lo_i;
      prev_aft = 1'b1;
      lo_v = 1'b0;
      lo_k = '0;
      lo_i = '0;
      for (int i = 0; i < DEPTH; i++) begin
         aft = c_v[i] && !earlier(ins_key, c_k[i]);
         if (!ins_en || aft) begin
            n_v[i] = c_v[i]; n_k[i] = c_k[i]; n_id[i] = c_id[i];
         end else if (prev_aft) begin
            n_v[i] = 1'b1;   n_k[i] = ins_key; n_id[i] = ins_id;
         end else begin
            n_v[i] = lo_v;   n_k[i] = lo_k;   n_id[i] = lo_i;
         end
         prev_aft = aft;
         lo_v = c_v[i];
         lo_k = c_k[i];
         lo_i = c_id[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            q_v[i]  <= 1'b0;
            q_k[i]  <= '0;
            q_id[i] <= '0;
         end
      end else if (rm_en || ins_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            q_v[i]  <= n_v[i];
            q_k[i]  <= n_k[i];
            q_id[i] <= n_id[i];
         end
      end
   end

   assign head_v   = q_v[0];
   assign head_key = q_k[0];
   assign head_id  = q_id[0];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !c_v[DEPTH-1]); // R8

   generate
      for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
         AST_SORTED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            q_v[g+1] |-> (q_v[g] && !earlier(q_k[g+1], q_k[g]))); // R3
      end
   endgenerate
endmodule

// File: rtl/edf_sched.sv
module edf_sched
   import edf_pkg::*;
#(
   parameter int unsigned NTASK = 8,
   parameter int unsigned TW    = 32,
   localparam int unsigned IW   = (NTASK > 1) ? $clog2(NTASK) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [2:0]    cmd_op,
   input  logic [IW-1:0] cmd_id,
   input  logic [TW-1:0] cmd_rdl,
   input  logic [TW-1:0] cmd_period,
   input  logic [TW-1:0] cmd_delay,
   output logic          cmd_err,
   output logic          cur_valid,
   output logic [IW-1:0] cur_id,
   output logic          cur_changed,
   output logic [TW-1:0] now_time
);
   generate
      if (NTASK < 2) begin : g_bad_ntask
         $error("edf_sched: NTASK must be at least 2");
      end
   endgenerate

   // task table
   logic          t_used  [NTASK];
   logic          t_cyc   [NTASK];
   logic          t_sleep [NTASK];
   logic [TW-1:0] t_rdl   [NTASK];
   logic [TW-1:0] t_per   [NTASK];
   logic [TW-1:0] t_dl    [NTASK];
   logic [TW-1:0] t_nrel  [NTASK];

   // latched command
   logic          busy;
   edf_op_e       l_op;
   logic [IW-1:0] l_id;
   logic [TW-1:0] l_rdl, l_per, l_dly;

   logic          rq_rm, rq_ins, wq_rm, wq_ins;
   logic [TW-1:0] rq_key, wq_key;
   logic          rq_hv, wq_hv, due;
   logic [TW-1:0] rq_hkey, wq_hkey;
   logic [IW-1:0] rq_hid, wq_hid, tid;
   logic          fail, do_new, do_kill, do_sleep, do_resume, do_release;
   logic          prev_v;
   logic [IW-1:0] prev_id;

   edf_time_base #(.TW(TW)) u_time (
      .clk(clk), .rst_n(rst_n), .wake_v(wq_hv), .wake_key(wq_hkey),
      .now(now_time), .due(due)
   );

   edf_pq #(.DEPTH(NTASK), .KW(TW), .IW(IW)) u_ready_q (
      .clk(clk), .rst_n(rst_n), .rm_en(rq_rm), .rm_id(tid),
      .ins_en(rq_ins), .ins_key(rq_key), .ins_id(tid),
      .head_v(rq_hv), .head_key(rq_hkey), .head_id(rq_hid)
   );

   edf_pq #(.DEPTH(NTASK), .KW(TW), .IW(IW)) u_wake_q (
      .clk(clk), .rst_n(rst_n), .rm_en(wq_rm), .rm_id(tid),
      .ins_en(wq_ins), .ins_key(wq_key), .ins_id(tid),
      .head_v(wq_hv), .head_key(wq_hkey), .head_id(wq_hid)
   );

   assign cmd_ready = !busy;
   assign tid       = busy ? l_id : wq_hid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         l_op  <= OP_IDLE;
         l_id  <= '0;
         l_rdl <= '0;
         l_per <= '0;
         l_dly <= '0;
      end else if (!busy && cmd_valid) begin
         busy  <= 1'b1;
         l_op  <= edf_op_e'(cmd_op);
         l_id  <= cmd_id;
         l_rdl <= cmd_rdl;
         l_per <= cmd_period;
         l_dly <= cmd_delay;
      end else begin
         busy  <= 1'b0;
      end
   end

   // decode: a command owns the execute cycle, otherwise one due event is served
   always_comb begin
      rq_rm = 1'b0; rq_ins = 1'b0; rq_key = '0;
      wq_rm = 1'b0; wq_ins = 1'b0; wq_key = '0;
      fail = 1'b0; do_new = 1'b0; do_kill = 1'b0; do_sleep = 1'b0;
      do_resume = 1'b0; do_release = 1'b0;
      if (busy) begin
         case (l_op)
            OP_NEW_ONESHOT, OP_NEW_CYCLIC: begin
               if (t_used[tid]) fail = 1'b1;
               else begin
                  do_new = 1'b1;
                  rq_ins = 1'b1;
                  rq_key = now_time + l_rdl;
                  if (l_op == OP_NEW_CYCLIC) begin
                     wq_ins = 1'b1;
                     wq_key = now_time + l_per;
                  end
               end
            end
            OP_KILL: begin
               if (!t_used[tid]) fail = 1'b1;
               else begin
                  do_kill = 1'b1; rq_rm = 1'b1; wq_rm = 1'b1;
               end
            end
            OP_SLEEP: begin
               if (!t_used[tid] || t_sleep[tid]) fail = 1'b1;
               else begin
                  do_sleep = 1'b1; rq_rm = 1'b1; wq_rm = 1'b1;
                  wq_ins = 1'b1;
                  wq_key = now_time + l_dly;
               end
            end
            default: ;
         endcase
      end else if (due) begin
         wq_rm = 1'b1;
         if (t_sleep[tid]) begin
            do_resume = 1'b1;
            rq_ins = 1'b1;
            rq_key = t_dl[tid];
            if (t_cyc[tid]) begin
               wq_ins = 1'b1;
               wq_key = t_nrel[tid];
            end
         end else begin
            do_release = 1'b1;
            rq_rm  = 1'b1;
            rq_ins = 1'b1;
            rq_key = t_nrel[tid] + t_rdl[tid];
            wq_ins = 1'b1;
            wq_key = t_nrel[tid] + t_per[tid];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NTASK; i++) begin
            t_used[i]  <= 1'b0;
            t_cyc[i]   <= 1'b0;
            t_sleep[i] <= 1'b0;
            t_rdl[i]   <= '0;
            t_per[i]   <= '0;
            t_dl[i]    <= '0;
            t_nrel[i]  <= '0;
         end
      end else begin
         if (do_new) begin
            t_used[tid]  <= 1'b1;
            t_cyc[tid]   <= (l_op == OP_NEW_CYCLIC);
            t_sleep[tid] <= 1'b0;
            t_rdl[tid]   <= l_rdl;
            t_per[tid]   <= l_per;
            t_dl[tid]    <= rq_key;
            t_nrel[tid]  <= wq_key;
         end
         if (do_kill) begin
            t_used[tid]  <= 1'b0;
            t_sleep[tid] <= 1'b0;
         end
         if (do_sleep)  t_sleep[tid] <= 1'b1;
         if (do_resume) t_sleep[tid] <= 1'b0;
         if (do_release) begin
            t_dl[tid]   <= rq_key;
            t_nrel[tid] <= wq_key;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_err <= 1'b0;
         prev_v  <= 1'b0;
         prev_id <= '0;
      end else begin
         cmd_err <= busy && fail;
         prev_v  <= cur_valid;
         prev_id <= cur_id;
      end
   end

   assign cur_valid   = rq_hv;
   assign cur_id      = rq_hid;
   assign cur_changed = (cur_valid != prev_v) || (cur_valid && (cur_id != prev_id));

   AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> cmd_ready); // R2
   AST_ERR_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(!cmd_ready)); // R8
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> !cmd_err); // R8
endmodule

// File: tb/edf_sched_tb_top.sv
module edf_sched_tb_top;
   localparam int CLK_NS = 10;
   localparam int NT     = 8;
   localparam int TW     = 10;
   localparam int IW     = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic [IW-1:0] cmd_id = '0;
   logic [TW-1:0] cmd_rdl = '0, cmd_period = '0, cmd_delay = '0;
   logic          cmd_err, cur_valid, cur_changed;
   logic [IW-1:0] cur_id;
   logic [TW-1:0] now_time;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #(CLK_NS/2) clk = ~clk;

   edf_sched #(.NTASK(NT), .TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_rdl(cmd_rdl), .cmd_period(cmd_period),
      .cmd_delay(cmd_delay), .cmd_err(cmd_err), .cur_valid(cur_valid),
      .cur_id(cur_id), .cur_changed(cur_changed), .now_time(now_time)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model built from the requirements ----------------
   bit            m_busy, m_err;
   logic [TW-1:0] m_now;
   int            m_op, m_id;
   logic [TW-1:0] m_lrdl, m_lper, m_ldly;
   bit            used[NT], cyc[NT], slp[NT];
   logic [TW-1:0] rdl[NT], per[NT], dl[NT], nrel[NT];
   bit            rv[NT], wv[NT];
   logic [TW-1:0] rk[NT], wk[NT];
   int            rs[NT], ws[NT];
   int            seq;
   bit            pv;
   int            pid;

   function automatic bit bef(input logic [TW-1:0] a, input logic [TW-1:0] b);
      logic [TW-1:0] d;
      d = a - b;
      return d[TW-1];
   endfunction

   task automatic head(input bit wq, output bit hv, output int hid);
      hv = 0; hid = 0;
      for (int i = 0; i < NT; i++) begin
         bit ok; logic [TW-1:0] k, bk; int s, bs;
         ok = wq ? wv[i] : rv[i];
         k  = wq ? wk[i] : rk[i];
         s  = wq ? ws[i] : rs[i];
         bk = wq ? wk[hid] : rk[hid];
         bs = wq ? ws[hid] : rs[hid];
         if (ok && (!hv || bef(k, bk) || (k == bk && s < bs))) begin
            hv = 1; hid = i;
         end
      end
   endtask

   task automatic rins(input int id, input logic [TW-1:0] k);
      rv[id] = 1; rk[id] = k; rs[id] = seq; seq++;
   endtask
   task automatic wins(input int id, input logic [TW-1:0] k);
      wv[id] = 1; wk[id] = k; ws[id] = seq; seq++;
   endtask

   task automatic m_exec();
      m_err = 0;
      case (m_op)
         1, 2: if (used[m_id]) m_err = 1;
               else begin
                  used[m_id] = 1; cyc[m_id] = (m_op == 2); slp[m_id] = 0;
                  rdl[m_id] = m_lrdl; per[m_id] = m_lper;
                  dl[m_id] = m_now + m_lrdl; rins(m_id, dl[m_id]);
                  if (m_op == 2) begin nrel[m_id] = m_now + m_lper; wins(m_id, nrel[m_id]); end
               end
         3: if (!used[m_id]) m_err = 1;
            else begin used[m_id] = 0; slp[m_id] = 0; rv[m_id] = 0; wv[m_id] = 0; end
         4: if (!used[m_id] || slp[m_id]) m_err = 1;
            else begin slp[m_id] = 1; rv[m_id] = 0; wins(m_id, m_now + m_ldly); end
         default: ;
      endcase
   endtask

   task automatic m_wake(input int id);
      if (slp[id]) begin
         slp[id] = 0; rins(id, dl[id]);
         if (cyc[id]) wins(id, nrel[id]); else wv[id] = 0;
      end else begin
         logic [TW-1:0] r;
         r = nrel[id];
         dl[id] = r + rdl[id]; nrel[id] = r + per[id];
         rins(id, dl[id]); wins(id, nrel[id]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_err = 0; m_now = '0; seq = 0; pv = 0; pid = 0;
         for (int i = 0; i < NT; i++) begin
            used[i] = 0; cyc[i] = 0; slp[i] = 0; rv[i] = 0; wv[i] = 0;
         end
      end else begin
         if (m_busy) begin
            m_exec();
            m_busy = 0;
         end else begin
            bit hv; int hid;
            m_err = 0;
            head(1, hv, hid);
            if (hv && !bef(m_now, wk[hid])) m_wake(hid);
            if (cmd_valid) begin
               m_busy = 1; m_op = int'(cmd_op); m_id = int'(cmd_id);
               m_lrdl = cmd_rdl; m_lper = cmd_period; m_ldly = cmd_delay;
            end
         end
         m_now = m_now + 1'b1;
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit ev, chg; int eid;
         head(0, ev, eid);
         chk(cur_valid == ev, "R3,R9,R11 cur_valid", cur_valid, ev);
         if (ev) chk(int'(cur_id) == eid, "R3,R5,R7,R9,R11 cur_id", cur_id, eid);
         chg = (ev != pv) || (ev && eid != pid);
         chk(cur_changed == chg, "R10 cur_changed", cur_changed, chg);
         pv = ev; pid = eid;
         chk(cmd_ready == !m_busy, "R2 cmd_ready", cmd_ready, !m_busy);
         chk(cmd_err == m_err, "R8 cmd_err", cmd_err, m_err);
         chk(now_time == m_now, "R1 now_time", now_time, m_now);
      end
   end

   // ---------------- stimulus ----------------
   // called right after a falling edge; returns after the execute edge, at a falling edge
   task automatic send(input int op, input int id, input int d, input int p, input int l,
                       output logic [TW-1:0] te);
      te = now_time + 1'b1;
      cmd_valid = 1; cmd_op = 3'(op); cmd_id = IW'(id);
      cmd_rdl = TW'(d); cmd_period = TW'(p); cmd_delay = TW'(l);
      @(negedge clk);
      cmd_valid = 0;
      @(negedge clk);
   endtask

   task automatic wait_until(input logic [TW-1:0] t);
      while (now_time != t) @(negedge clk);
   endtask

   initial begin
      #(CLK_NS * 190000);
      n_err++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [TW-1:0] t, t5, ts, tp;
      void'($urandom(32'd2417));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cur_valid == 0, "R1 cur_valid after reset", cur_valid, 0);
      chk(cmd_ready == 1, "R1 cmd_ready after reset", cmd_ready, 1);
      chk(cmd_err == 0, "R1 cmd_err after reset", cmd_err, 0);
      chk(now_time == 1, "R1 now_time after reset", now_time, 1);

      send(1, 2, 50, 0, 0, t);
      send(1, 5, 20, 0, 0, t5);
      chk(cur_id == 5, "R4 earliest one-shot selected", cur_id, 5);
      chk(cmd_err == 0, "R4 create accepted", cmd_err, 0);
      send(1, 3, int'(TW'(t5 + 20 - (now_time + 1'b1))), 0, 0, t);
      chk(cur_id == 5, "R3 equal deadline keeps older task", cur_id, 5);
      send(1, 2, 10, 0, 0, t);
      chk(cmd_err == 1, "R8 create on used id", cmd_err, 1);
      chk(cur_id == 5, "R8 refused create changes nothing", cur_id, 5);
      send(3, 5, 0, 0, 0, t);
      chk(cur_id == 3, "R6 kill selects next", cur_id, 3);
      send(3, 7, 0, 0, 0, t);
      chk(cmd_err == 1, "R8 kill on free id", cmd_err, 1);
      send(4, 3, 0, 0, 10, ts);
      chk(cur_id == 2, "R7 sleeper leaves ready set", cur_id, 2);
      send(4, 3, 0, 0, 5, t);
      chk(cmd_err == 1, "R8 sleep on sleeping id", cmd_err, 1);
      wait_until(ts + 8);
      chk(cur_id == 2, "R7 still asleep before wake", cur_id, 2);
      wait_until(ts + 12);
      chk(cur_id == 3, "R7 resumed with old deadline", cur_id, 3);
      send(3, 3, 0, 0, 0, t);
      send(3, 2, 0, 0, 0, t);
      chk(cur_valid == 0, "R6 no task left", cur_valid, 0);

      send(2, 1, 3, 20, 0, tp);
      chk(cur_valid == 1 && cur_id == 1, "R5 repeating task ready", cur_id, 1);
      send(1, 4, int'(TW'(tp + 10 - (now_time + 1'b1))), 0, 0, t);
      chk(cur_id == 1, "R5 first deadline earliest", cur_id, 1);
      wait_until(tp + 15);
      chk(cur_id == 1, "R5 before release", cur_id, 1);
      wait_until(tp + 24);
      chk(cur_id == 4, "R5 release pushed deadline out", cur_id, 4);
      send(3, 1, 0, 0, 0, t);
      send(3, 4, 0, 0, 0, t);

      // constrained random phase, counter wraps many times
      for (int it = 0; it < 2500; it++) begin
         int gap;
         gap = $urandom % 12;
         repeat (gap) @(negedge clk);
         for (int i = 0; i < NT; i++) begin
            logic [TW-1:0] age;
            age = now_time - dl[i];
            if (used[i] && !cyc[i] && !age[TW-1] && age > 150) send(3, i, 0, 0, 0, t);
         end
         send($urandom % 5, $urandom % NT, 1 + $urandom % 100, 20 + $urandom % 81,
              $urandom % 61, t);
      end
      repeat (4) @(negedge clk);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule